// File: doc/BRIEF.md
# Vsync-Clocked One-Way Display Data Transmitter

This block sends a monitor's identification bytes over the one-way display data channel. In this mode the serial clock line is not used, and the vertical-sync pulse from the video source acts as the bit clock. Each rising Vsync edge that the block sees puts one new bit on the open-drain data line. A frame is eight data bits, most significant first, followed by a forced trailing '1'.

Firmware writes the next byte into a holding register. Inside the block, a shift register drives the line. When the shift register runs empty, the next Vsync edge copies the holding register into it, drives out its top bit at once, and sets a sticky interrupt flag. Firmware then clears the flag and preloads the following byte. If firmware writes nothing new, the same byte goes out again.

Each time the block is enabled, it first drains whatever the shift register still holds. This takes nine edges, and the first fresh byte is loaded on the edge after them. Vsync is brought into the system clock domain through a synchronizer, and a one-cycle edge strobe is derived from it. Selecting the bidirectional mode, or disabling the bus, releases both lines.

Top module: `vsync_serial_tx`

## Requirements
- R1: Reset values: one-way mode is selected and the bus is disabled (`ctl_disable`=1). `sda_oe`, `scl_oe`, `pin_sel` and `irq` are 0. The shift register holds all ones, and the holding register holds zero.
- R2: While the block is active, `scl_oe` stays 0. `sda_oe` changes only after a synchronized Vsync rising edge: `sda_oe`=1 means a '0' bit pulls the line low, and `sda_oe`=0 means a '1' bit releases it.
- R3: After each enable, the first nine Vsync rising edges drain the shift register. The first eight send its stale contents MSB first, the ninth sends '1', and `irq` is not set.
- R4: On the edge after the shift register becomes empty, the holding register is loaded, its MSB is driven on that same edge, and `irq` is set.
- R5: A loaded byte occupies nine edges: the load edge, seven further data bits in descending order, then a '1'. The edge after these nine loads the next byte and sets `irq` again.
- R6: `irq` stays set until a cycle with `irq_clr`=1. A load in the same cycle keeps it set.
- R7: If the holding register is not rewritten between two loads, the same byte is sent again.
- R8: The block is active only when `ctl_oneway`=1 and `ctl_disable`=0. When it is not active, `sda_oe` and `scl_oe` are 0. `pin_sel` equals the inverse of the disable bit, whatever the mode.
- R9: Disabling the block resets its bit counter. Vsync edges that arrive while it is inactive are ignored. The next enable repeats the nine-edge drain, using whatever bits were left in the shift register, with the vacated positions filled by ones.
- R10: While no Vsync edge arrives, the data line holds its value.

Top module port list order is used below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_in | input | 1 | Vertical-sync pulse, asynchronous to clk |
| data_wr | input | 1 | Strobe that writes `data_in` into the holding register |
| data_in | input | DATA_W | Next byte to transmit |
| ctl_wr | input | 1 | Strobe that writes the two control bits |
| ctl_oneway | input | 1 | 1 selects the Vsync-clocked one-way mode, 0 the bidirectional mode |
| ctl_disable | input | 1 | 0 activates the bus function |
| irq_clr | input | 1 | Clears the load interrupt |
| irq | output | 1 | Sticky flag, set when a byte is loaded |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| scl_oe | output | 1 | Pulls the clock line low when 1 (never in this mode) |
| pin_sel | output | 1 | Hands the two shared pins to the bus function |

## Verification
The assertions assume that Vsync is slow compared with the system clock, so that each edge yields exactly one strobe and the strobes are spaced many cycles apart. The 25 kHz ceiling on Vsync makes this true in practice. The bench respects this by holding each Vsync level for four clock cycles. It changes the control bits and writes bytes only between Vsync pulses, and it samples outputs only once the synchronizer has settled after the last pulse.

// File: rtl/vstx_pkg.sv
package vstx_pkg;

    typedef struct packed {
        logic oneway;
        logic disabled;
    } vstx_ctl_t;

    localparam vstx_ctl_t CTL_RESET = '{oneway: 1'b1, disabled: 1'b1};

endpackage

// File: rtl/vstx_edge_sync.sv
module vstx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_stb
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_stb = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];

endmodule

// File: rtl/vstx_host_regs.sv
module vstx_host_regs
    import vstx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ctl_wr,
    input  logic              ctl_oneway,
    input  logic              ctl_disable,
    input  logic              irq_clr,
    input  logic              load_stb,
    output vstx_ctl_t         ctl,
    output logic [DATA_W-1:0] hold_byte,
    output logic              irq
);
    typedef struct packed {
        vstx_ctl_t         ctl;
        logic [DATA_W-1:0] hold;
        logic              irq;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctl_wr) begin
            r_d.ctl.oneway   = ctl_oneway;
            r_d.ctl.disabled = ctl_disable;
        end
        if (data_wr) r_d.hold = data_in;
        if (load_stb)     r_d.irq = 1'b1;
        else if (irq_clr) r_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctl  <= CTL_RESET;
            r_q.hold <= '0;
            r_q.irq  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl       = r_q.ctl;
    assign hold_byte = r_q.hold;
    assign irq       = r_q.irq;

endmodule

// File: rtl/vstx_frame_engine.sv
module vstx_frame_engine #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              edge_stb,
    input  logic [DATA_W-1:0] hold_byte,
    output logic              line_bit,
    output logic              load_stb,
    output logic              empty,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam int              MSB      = DATA_W - 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              empty;
        logic              bit_out;
    } eng_t;

    eng_t e_d, e_q;
    logic load_c;

    always_comb begin
        e_d    = e_q;
        load_c = 1'b0;
        if (!active) begin
            e_d.cnt     = '0;
            e_d.empty   = 1'b0;
            e_d.bit_out = 1'b1;
        end else if (edge_stb) begin
            if (e_q.empty) begin
                load_c      = 1'b1;
                e_d.bit_out = hold_byte[MSB];
                e_d.sh      = {hold_byte[MSB-1:0], 1'b1};
                e_d.cnt     = CNT_W'(1);
                e_d.empty   = 1'b0;
            end else if (e_q.cnt == LAST_CNT) begin
                e_d.bit_out = 1'b1;
                e_d.cnt     = '0;
                e_d.empty   = 1'b1;
            end else begin
                e_d.bit_out = e_q.sh[MSB];
                e_d.sh      = {e_q.sh[MSB-1:0], 1'b1};
                e_d.cnt     = e_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q.sh      <= '1;
            e_q.cnt     <= '0;
            e_q.empty   <= 1'b0;
            e_q.bit_out <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign line_bit = e_q.bit_out;
    assign load_stb = load_c;
    assign empty    = e_q.empty;
    assign bit_cnt  = e_q.cnt;

endmodule

// File: rtl/vsync_serial_tx.sv
module vsync_serial_tx
    import vstx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_in,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ctl_wr,
    input  logic              ctl_oneway,
    input  logic              ctl_disable,
    input  logic              irq_clr,
    output logic              irq,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              pin_sel
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    vstx_ctl_t         ctl;
    logic [DATA_W-1:0] hold_byte;
    logic              edge_stb;
    logic              active;
    logic              line_bit;
    logic              load_stb;
    logic              empty;
    logic [CNT_W-1:0]  bit_cnt;

    vstx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (vsync_in),
        .rise_stb (edge_stb)
    );

    vstx_host_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_wr     (data_wr),
        .data_in     (data_in),
        .ctl_wr      (ctl_wr),
        .ctl_oneway  (ctl_oneway),
        .ctl_disable (ctl_disable),
        .irq_clr     (irq_clr),
        .load_stb    (load_stb),
        .ctl         (ctl),
        .hold_byte   (hold_byte),
        .irq         (irq)
    );

    assign active = ctl.oneway & ~ctl.disabled;

    vstx_frame_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .edge_stb  (edge_stb),
        .hold_byte (hold_byte),
        .line_bit  (line_bit),
        .load_stb  (load_stb),
        .empty     (empty),
        .bit_cnt   (bit_cnt)
    );

    assign sda_oe  = active & ~line_bit;
    assign scl_oe  = 1'b0;
    assign pin_sel = ~ctl.disabled;

endmodule

// File: rtl/vstx_checker.sv
module vstx_checker #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              edge_stb,
    input logic              active,
    input logic              line_bit,
    input logic              empty,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              irq,
    input logic              irq_clr,
    input logic              load_stb,
    input logic [DATA_W-1:0] hold_byte,
    input logic              sda_oe
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);

    AST_LINE_HOLDS_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_stb && active) |=> $stable(line_bit)); // R10

    AST_RELEASED_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sda_oe); // R8

    AST_LOAD_DRIVES_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_stb && active && empty) |=> (line_bit == $past(hold_byte[DATA_W-1]) && irq)); // R4

    AST_TRAILING_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_stb && active && !empty && bit_cnt == LAST_CNT) |=> (line_bit && empty)); // R5

    AST_IRQ_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(load_stb)); // R4

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R6

    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !load_stb) |=> !irq); // R6

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= LAST_CNT); // R5

    AST_IDLE_RESETS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (bit_cnt == '0 && !empty)); // R9

endmodule

bind vsync_serial_tx vstx_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_stb  (edge_stb),
    .active    (active),
    .line_bit  (line_bit),
    .empty     (empty),
    .bit_cnt   (bit_cnt),
    .irq       (irq),
    .irq_clr   (irq_clr),
    .load_stb  (load_stb),
    .hold_byte (hold_byte),
    .sda_oe    (sda_oe)
);

// File: tb/vsync_serial_tx_bench.sv
module vsync_serial_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             vsync_in = 1'b0;
    logic             data_wr = 1'b0;
    logic [DATA_W-1:0] data_in = '0;
    logic             ctl_wr = 1'b0;
    logic             ctl_oneway = 1'b0;
    logic             ctl_disable = 1'b0;
    logic             irq_clr = 1'b0;
    logic             irq, sda_oe, scl_oe, pin_sel;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsync_serial_tx #(.DATA_W(DATA_W)) u_vsync_serial_tx (
        .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in),
        .data_wr(data_wr), .data_in(data_in),
        .ctl_wr(ctl_wr), .ctl_oneway(ctl_oneway), .ctl_disable(ctl_disable),
        .irq_clr(irq_clr), .irq(irq), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .pin_sel(pin_sel)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // line level: 1 = released ('1' bit), 0 = pulled low
    function automatic logic line_level();
        return ~sda_oe;
    endfunction

    task automatic vs_pulse();
        @(negedge clk) vsync_in = 1'b1;
        repeat (4) @(negedge clk);
        vsync_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_ctl(input logic oneway, input logic dis);
        @(negedge clk);
        ctl_oneway = oneway; ctl_disable = dis; ctl_wr = 1'b1;
        @(negedge clk) ctl_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_byte(input logic [DATA_W-1:0] b);
        @(negedge clk);
        data_in = b; data_wr = 1'b1;
        @(negedge clk) data_wr = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        @(negedge clk);
    endtask

    // sends the remaining 7 data bits and the trailing one of a loaded byte
    task automatic finish_frame(input logic [DATA_W-1:0] b, input string tag);
        for (int i = DATA_W - 2; i >= 0; i--) begin
            vs_pulse();
            chk({tag, " data bit"}, line_level(), b[i]);
        end
        vs_pulse();
        chk({tag, " trailing one"}, line_level(), 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 sda_oe at reset", sda_oe, 1'b0);
        chk("R1 scl_oe at reset", scl_oe, 1'b0);
        chk("R1 pin_sel at reset", pin_sel, 1'b0);
        chk("R1 irq at reset", irq, 1'b0);
    endtask

    task automatic t_inactive();
        vs_pulse(); vs_pulse();
        chk("R8 disabled sda released", sda_oe, 1'b0);
        chk("R8 disabled no irq", irq, 1'b0);
        set_ctl(1'b0, 1'b0);
        chk("R8 bidir mode pin_sel", pin_sel, 1'b1);
        vs_pulse(); vs_pulse();
        chk("R8 bidir mode sda released", sda_oe, 1'b0);
        chk("R8 bidir mode scl released", scl_oe, 1'b0);
        chk("R8 bidir mode no irq", irq, 1'b0);
        set_ctl(1'b1, 1'b1);
        chk("R8 disabled pin_sel", pin_sel, 1'b0);
    endtask

    task automatic t_flush_and_load();
        write_byte(8'hA5);
        set_ctl(1'b1, 1'b0);
        chk("R8 enabled pin_sel", pin_sel, 1'b1);
        for (int i = 0; i < 9; i++) begin
            vs_pulse();
            chk("R3 R1 drain bit from all-ones shift reg", line_level(), 1'b1);
            chk("R3 no irq during drain", irq, 1'b0);
        end
        vs_pulse();
        chk("R4 load drives msb", line_level(), 1'b1);
        chk("R4 irq on load", irq, 1'b1);
        repeat (20) @(negedge clk);
        chk("R10 line holds without edge", line_level(), 1'b1);
        chk("R2 scl released while active", scl_oe, 1'b0);
        chk("R6 irq sticky", irq, 1'b1);
        clear_irq();
        chk("R6 irq cleared", irq, 1'b0);
        write_byte(8'h3C);
        finish_frame(8'hA5, "R5 byte A5");
        chk("R5 no irq before next load", irq, 1'b0);
        vs_pulse();
        chk("R5 next load msb of 3C", line_level(), 1'b0);
        chk("R2 sda_oe pulls low for zero", sda_oe, 1'b1);
        chk("R5 irq on next load", irq, 1'b1);
        clear_irq();
        finish_frame(8'h3C, "R5 byte 3C");
    endtask

    task automatic t_repeat();
        vs_pulse();
        chk("R7 repeat load msb", line_level(), 1'b0);
        chk("R7 irq on repeat load", irq, 1'b1);
        clear_irq();
        // two more data bits of 3C leave shift reg = {3C[4:0],111} = 8'hE7
        vs_pulse();
        chk("R7 repeat bit 6", line_level(), 1'b0);
        vs_pulse();
        chk("R7 repeat bit 5", line_level(), 1'b1);
    endtask

    task automatic t_reenable();
        logic [DATA_W-1:0] stale;
        stale = 8'hE7;
        set_ctl(1'b1, 1'b1);
        chk("R9 disable releases sda", sda_oe, 1'b0);
        vs_pulse(); vs_pulse(); vs_pulse();
        chk("R9 edges while disabled no irq", irq, 1'b0);
        write_byte(8'h5A);
        set_ctl(1'b1, 1'b0);
        for (int i = DATA_W - 1; i >= 0; i--) begin
            vs_pulse();
            chk("R9 R3 drain stale bit", line_level(), stale[i]);
            chk("R9 no irq during drain", irq, 1'b0);
        end
        vs_pulse();
        chk("R9 R3 drain trailing one", line_level(), 1'b1);
        chk("R9 no irq after drain", irq, 1'b0);
        vs_pulse();
        chk("R9 R4 load after re-enable msb", line_level(), 1'b0);
        chk("R9 R4 irq after re-enable", irq, 1'b1);
        finish_frame(8'h5A, "R5 byte 5A");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inactive();
        t_flush_and_load();
        t_repeat();
        t_reenable();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule